// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives clause-22 management frames on an MDIO/MDC pair to read and write registers inside an Ethernet PHY. A host writes four small registers through a simple write port. Register select 0 holds the target PHY and register addresses. Register select 1 holds the read command bit. Register select 2 is the write-data register, and a write to it starts a write frame at once. Register select 3 holds the MDC divider and a management reset bit. The host then polls `busy` until it drops. After a read frame ends, the 16-bit value returned by the PHY appears on `rd_data`.

Frame sequencing is done by an enumerated state machine: `ST_IDLE`, `ST_PREAMBLE`, `ST_HEADER` (start, opcode, addresses), `ST_TURN` and `ST_DATA`. The named transitions are as follows:
- launch: `ST_IDLE` to `ST_PREAMBLE`.
- preamble done after bit 31: to `ST_HEADER`.
- header done after bit 45: to `ST_TURN`.
- turnaround done after bit 47: to `ST_DATA`.
- frame done after bit 63: back to `ST_IDLE`.
- management reset: from any state to `ST_IDLE`.

A separate divider produces MDC. It runs only while a frame is in flight, and it flags the rising and falling edges. The state machine uses the falling-edge flag to advance bits and the rising-edge flag to sample read data.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The PHY address is taken from bits [12:8] of the address register (select 0), and the PHY register address is taken from bits [4:0]. Both are sent MSB first in the frame header.
- R2: A write to the write-data register (select 2) starts a 64-bit write frame. The frame is sent MSB first and consists of 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register address, turnaround 10 and the 16 data bits. `mdio_oe` is 1 for every bit of the frame.
- R3: A read frame starts only when bit 0 of the command register (select 1) is written as 1 while its stored value is 0. The read frame uses opcode 10. The master drives the first 46 bits and releases MDIO (`mdio_oe`=0) for the two turnaround bits and the 16 data bits.
- R4: During a read, MDIO is sampled on each rising MDC edge of the 16 data bits. The bits are assembled MSB first, and the result appears on `rd_data` when the frame ends. `rd_data` is unchanged by write frames.
- R5: `busy` rises in the cycle after the launching register write. It stays high for exactly 128*H system clock cycles, where H is the effective half period.
- R6: MDC has a period of 2*H system clocks. H is taken from bits [7:0] of the configuration register (select 3), a field value of 0 acts as 1, and the reset value 22 gives divide-by-44. MDC is low whenever `busy` is low.
- R7: The value on `mdio_o` changes only while MDC is low. It never changes across a cycle in which MDC stays high.
- R8: Launch attempts (write-data writes or read-bit sets) made while a frame is in flight are ignored. They neither start a second frame nor alter the one in progress.
- R9: Clearing the read bit while a read frame is in flight does not abort the frame. `rd_data` still receives the PHY value.
- R10: While bit 15 of the configuration register is 1 (management reset), the state machine returns to idle within one cycle. `busy`, `mdio_oe` and MDC go low, and launches are ignored.
- R11: After reset, `busy`, `mdc` and `mdio_oe` are 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 command, 2 write data, 3 configuration |
| reg_wdata | input | 16 | Register write value |
| mdio_i | input | 1 | MDIO input from the pad |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| busy | output | 1 | Frame in flight |
| rd_data | output | 16 | Last read result |

## Verification
The assertions check the following on every cycle:
- MDIO holds still while MDC is high.
- MDC and the output enable are low whenever the block is idle.
- `busy` cannot drop except on a falling MDC edge or a management reset.
- A launch arriving mid-frame leaves the bit position untouched.
- The management reset empties the machine one cycle later.

Only the bench scenarios can show the following:
- The frame contents bit for bit.
- The released turnaround on reads.
- The data that comes back from the PHY model.
- The exact MDC period and frame length for several divider settings.
- That the read bit acts on its 0-to-1 change.
- That a read survives its command bit being cleared.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_e;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_CMD   = 2'd1;
    localparam logic [1:0] SEL_WDATA = 2'd2;
    localparam logic [1:0] SEL_CFG   = 2'd3;

    localparam logic [1:0] OP_WRITE  = 2'b01;
    localparam logic [1:0] OP_READ   = 2'b10;
    localparam logic [1:0] START_SEQ = 2'b01;
    localparam logic [1:0] TA_DRIVEN = 2'b10;
    localparam int         PRE_BITS  = 32;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_cnt,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last_cnt;
    logic             mdc_q;
    logic             wrap;

    assign last_cnt = (half_cnt == '0) ? '0 : half_cnt - 1'b1;
    assign wrap     = run && (cnt_q == last_cnt);
    assign rise_evt = wrap && !mdc_q;
    assign fall_evt = wrap && mdc_q;
    assign mdc      = mdc_q && run;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the divider parks its clock low once the frame stops
    p_mdc_parks_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc_q);

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
#(
    parameter int PHY_W  = 5,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_rst,
    input  logic              launch_wr,
    input  logic              launch_rd,
    input  logic [PHY_W-1:0]  phy_addr,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_word
);

    localparam int FRAME_W  = PRE_BITS + 4 + PHY_W + REG_W + 2 + DATA_W;
    localparam int IDX_W    = $clog2(FRAME_W);
    localparam int PRE_LAST = PRE_BITS - 1;
    localparam int HDR_LAST = PRE_BITS + 4 + PHY_W + REG_W - 1;
    localparam int TA_LAST  = HDR_LAST + 2;
    localparam int END_LAST = FRAME_W - 1;

    mdio_state_e          state_q, state_d;
    logic [IDX_W-1:0]     idx_q;
    logic [FRAME_W-1:0]   frame_q;
    logic                 is_rd_q;
    logic [DATA_W-1:0]    rx_q;
    logic [DATA_W-1:0]    rd_q;
    logic                 start;

    assign start = (state_q == ST_IDLE) && !mgmt_rst && (launch_wr || launch_rd);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_evt && idx_q == IDX_W'(PRE_LAST)) state_d = ST_HEADER;
            ST_HEADER:   if (fall_evt && idx_q == IDX_W'(HDR_LAST)) state_d = ST_TURN;
            ST_TURN:     if (fall_evt && idx_q == IDX_W'(TA_LAST))  state_d = ST_DATA;
            ST_DATA:     if (fall_evt && idx_q == IDX_W'(END_LAST)) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (mgmt_rst) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            frame_q <= '1;
            is_rd_q <= 1'b0;
            rx_q    <= '0;
            rd_q    <= '0;
        end else if (mgmt_rst) begin
            idx_q   <= '0;
            is_rd_q <= 1'b0;
        end else if (start) begin
            idx_q   <= '0;
            is_rd_q <= launch_rd;
            frame_q <= {{PRE_BITS{1'b1}}, START_SEQ, launch_rd ? OP_READ : OP_WRITE,
                        phy_addr, reg_addr, TA_DRIVEN,
                        launch_rd ? {DATA_W{1'b1}} : wr_word};
        end else begin
            if (rise_evt && state_q == ST_DATA && is_rd_q)
                rx_q <= {rx_q[DATA_W-2:0], mdio_i};
            if (fall_evt && state_q != ST_IDLE) begin
                frame_q <= {frame_q[FRAME_W-2:0], 1'b1};
                idx_q   <= idx_q + 1'b1;
                if (state_q == ST_DATA && idx_q == IDX_W'(END_LAST) && is_rd_q)
                    rd_q <= rx_q;
            end
        end
    end

    always_comb begin
        busy    = (state_q != ST_IDLE);
        mdio_oe = busy && !(is_rd_q && (state_q == ST_TURN || state_q == ST_DATA));
        mdio_o  = busy ? frame_q[FRAME_W-1] : 1'b1;
        rd_word = rd_q;
    end

    // R5: a frame only ends on a falling MDC edge or a management reset
    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mgmt_rst && !fall_evt) |=> busy);

    // R10: management reset empties the machine one cycle later
    p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rst |=> (!busy && !mdio_oe));

    // R8: a launch during a frame leaves the bit position alone
    p_launch_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mgmt_rst && !fall_evt && (launch_wr || launch_rd)) |=> $stable(idx_q));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 22,
    parameter int PHY_W     = 5,
    parameter int REG_W     = 5,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PHY_LSB = 8;
    localparam int RST_BIT = DATA_W - 1;

    logic [PHY_W-1:0] phy_q;
    logic [REG_W-1:0] regad_q;
    logic             rd_cmd_q;
    logic [DIV_W-1:0] half_q;
    logic             mgmt_rst_q;
    logic             launch_wr, launch_rd;
    logic             rise_evt, fall_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q      <= '0;
            regad_q    <= '0;
            rd_cmd_q   <= 1'b0;
            half_q     <= DIV_W'(DIV_RESET);
            mgmt_rst_q <= 1'b0;
        end else if (reg_wr) begin
            unique case (reg_sel)
                SEL_ADDR: begin
                    phy_q   <= reg_wdata[PHY_LSB +: PHY_W];
                    regad_q <= reg_wdata[REG_W-1:0];
                end
                SEL_CMD:  rd_cmd_q <= reg_wdata[0];
                SEL_CFG: begin
                    half_q     <= reg_wdata[DIV_W-1:0];
                    mgmt_rst_q <= reg_wdata[RST_BIT];
                end
                default: ;
            endcase
        end
    end

    assign launch_wr = reg_wr && (reg_sel == SEL_WDATA) && !mgmt_rst_q;
    assign launch_rd = reg_wr && (reg_sel == SEL_CMD) && reg_wdata[0] && !rd_cmd_q && !mgmt_rst_q;

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_cnt (half_q),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_fsm #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mgmt_rst  (mgmt_rst_q),
        .launch_wr (launch_wr),
        .launch_rd (launch_rd),
        .phy_addr  (phy_q),
        .reg_addr  (regad_q),
        .wr_word   (reg_wdata),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_word   (rd_data)
    );

    // R7: data on the wire moves only while MDC is low
    p_mdio_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

    // R11 / R6: an idle block drives nothing and keeps MDC low
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe, busy;
    logic [15:0] rd_data;

    always #4 clk = ~clk;

    mdio_mgmt_master i_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .busy(busy), .rd_data(rd_data)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [63:0] cap_bits = '0;
    logic [63:0] cap_oe   = '0;
    logic [15:0] phy_data = 16'h0000;
    logic        mdc_prev = 1'b0;
    logic        busy_prev = 1'b0;
    int k = 64, bc = 0, frames = 0, since_rise = 0, last_per = 0;

    // PHY model and wire monitor, mid-cycle
    always @(negedge clk) begin
        cyc++;
        if (busy && !busy_prev) begin
            k = 0; bc = 0; frames++; since_rise = 0;
        end
        if (busy) bc++;
        since_rise++;
        if (busy && mdc && !mdc_prev) begin
            if (k < 64) begin
                cap_bits[63-k] = mdio_o;
                cap_oe[63-k]   = mdio_oe;
            end
            k++;
            last_per = since_rise;
            since_rise = 0;
        end
        if (busy && !mdc && mdc_prev)
            mdio_i = (k >= 48 && k <= 63) ? phy_data[63-k] : 1'b1;
        if (!busy) mdio_i = 1'b1;
        mdc_prev  = mdc;
        busy_prev = busy;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [63:0] exp_frame(bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r, 2'b10, d};
    endfunction

    function automatic int eff_half(int h);
        if (h < 0)  return 22;
        if (h == 0) return 1;
        return h;
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [1:0] sel, logic [15:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    endtask

    task automatic set_target(int h, logic [4:0] p, logic [4:0] r);
        if (h >= 0) wr_reg(2'd3, 16'(h));
        wr_reg(2'd0, {3'b000, p, 3'b000, r});
    endtask

    task automatic do_write(int h, logic [4:0] p, logic [4:0] r, logic [15:0] d);
        int f0;
        logic [63:0] e;
        logic [15:0] rd0;
        set_target(h, p, r);
        f0 = frames; rd0 = rd_data;
        e = exp_frame(1'b0, p, r, d);
        wr_reg(2'd2, d);
        check(busy == 1'b1, "R5 busy after write launch", 64'(busy), 64'd1);
        wait_idle();
        check(cap_bits == e, "R1 R2 write frame bits", cap_bits, e);
        check(cap_oe == '1, "R2 write drives all bits", cap_oe, '1);
        check(bc == 128 * eff_half(h), "R5 busy length", 64'(bc), 64'(128 * eff_half(h)));
        check(last_per == 2 * eff_half(h), "R6 MDC period", 64'(last_per), 64'(2 * eff_half(h)));
        check(frames == f0 + 1 && rd_data == rd0, "R4 write leaves rd_data, one frame",
              {32'(frames), 16'd0, rd_data}, {32'(f0 + 1), 16'd0, rd0});
    endtask

    task automatic do_read(int h, logic [4:0] p, logic [4:0] r, logic [15:0] d);
        logic [63:0] e;
        set_target(h, p, r);
        phy_data = d;
        e = exp_frame(1'b1, p, r, 16'h0);
        wr_reg(2'd1, 16'h0001);
        wait_idle();
        check(cap_bits[63:18] == e[63:18], "R3 read header bits", 64'(cap_bits[63:18]), 64'(e[63:18]));
        check(cap_oe == {{46{1'b1}}, 18'b0}, "R3 read releases MDIO", cap_oe, {{46{1'b1}}, 18'b0});
        check(rd_data == d, "R4 read data", 64'(rd_data), 64'(d));
        check(last_per == 2 * eff_half(h), "R6 MDC period on read", 64'(last_per), 64'(2 * eff_half(h)));
        wr_reg(2'd1, 16'h0000);
    endtask

    initial begin
        int f0;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        check(busy == 0 && mdc == 0 && mdio_oe == 0 && rd_data == 0, "R11 reset state",
              {busy, mdc, mdio_oe, rd_data}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_write(-1, 5'h01, 5'h00, 16'h8000);      // R6 default divide-by-44
        do_write(0, 5'h1F, 5'h1F, 16'hFFFF);       // R6 zero field acts as 1
        do_read(1, 5'h00, 5'h01, 16'h0000);
        do_read(2, 5'h15, 5'h0A, 16'hFFFF);

        for (int n = 0; n < 8; n++) begin
            int h = 1 + int'($urandom % 4);
            logic [4:0] p = 5'($urandom);
            logic [4:0] r = 5'($urandom);
            logic [15:0] d = 16'($urandom);
            if ($urandom % 2 == 0) do_write(h, p, r, d);
            else                   do_read(h, p, r, d);
        end

        // R3: read bit already set, second set does not launch
        do_read(2, 5'h03, 5'h04, 16'h5AA5);
        wr_reg(2'd1, 16'h0001);
        wait_idle();
        wr_reg(2'd1, 16'h0001);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R3 no launch without 0-to-1 change", 64'(busy), 64'd0);
        wr_reg(2'd1, 16'h0000);

        // R8: launches during a frame are ignored
        set_target(2, 5'h0C, 5'h11);
        f0 = frames;
        wr_reg(2'd2, 16'hA5A5);
        repeat (20) @(negedge clk);
        wr_reg(2'd2, 16'h1234);
        wr_reg(2'd1, 16'h0001);
        wait_idle();
        repeat (5) @(negedge clk);
        check(frames == f0 + 1 && !busy, "R8 one frame only", 64'(frames), 64'(f0 + 1));
        check(cap_bits == exp_frame(1'b0, 5'h0C, 5'h11, 16'hA5A5), "R8 frame unaltered",
              cap_bits, exp_frame(1'b0, 5'h0C, 5'h11, 16'hA5A5));
        wr_reg(2'd1, 16'h0000);

        // R9: clearing the read bit mid-frame does not abort
        set_target(2, 5'h02, 5'h07);
        phy_data = 16'h3C96;
        f0 = frames;
        wr_reg(2'd1, 16'h0001);
        repeat (60) @(negedge clk);
        wr_reg(2'd1, 16'h0000);
        check(busy == 1'b1, "R9 still busy after clear", 64'(busy), 64'd1);
        wait_idle();
        check(rd_data == 16'h3C96 && frames == f0 + 1, "R9 read completes",
              64'(rd_data), 64'h3C96);

        // R10: management reset
        set_target(3, 5'h04, 5'h05);
        wr_reg(2'd2, 16'hBEEF);
        repeat (100) @(negedge clk);
        wr_reg(2'd3, 16'h8003);
        @(negedge clk);
        check(busy == 0 && mdio_oe == 0 && mdc == 0, "R10 reset forces idle",
              {busy, mdio_oe, mdc}, 64'd0);
        wr_reg(2'd2, 16'h1111);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10 launch ignored in reset", 64'(busy), 64'd0);
        wr_reg(2'd3, 16'h0003);
        do_write(3, 5'h04, 5'h05, 16'h0F0F);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule